// File: doc/BRIEF.md
# Floating-point mantissa rounder with inexact trap control

This block rounds an extended-precision mantissa to a selected precision and decides the inexact exceptions that follow. Each operation carries a sign, a 64-bit mantissa with extra low-order bits below it, a rounding mode and a description of its destination. From the destination the block picks the precision: the control precision field, the destination's own format, or a forced precision. It rounds with guard, round and sticky information and always delivers the rounded result. It also flags inexactness, reports a mantissa carry-out so the exponent path can renormalize, and decides whether an enabled inexact trap is taken right after the instruction or left pending until the next floating-point instruction.

Operations enter through a valid/ready stream and leave through a single registered valid/ready stage. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or being drained that cycle, so the block runs at one operation per clock when it is not stalled. While `out_valid` is high and `out_ready` is low, the output payload holds steady and no new input is taken. The sticky inexact flag and the pending-exception flag are plain level outputs, and each has its own clearing input.

Top module: `fp_round_trap`

## Requirements
- R1: Mode code 00 rounds to nearest. On an exact tie between the two neighbours, it picks the neighbour whose least significant kept bit is 0.
- R2: Mode code 01 truncates. Every discarded bit is dropped, the magnitude never grows, and `out_carry` stays 0.
- R3: Mode code 10 rounds toward minus infinity. An inexact negative value rounds up in magnitude, and an inexact positive value is truncated.
- R4: Mode code 11 rounds toward plus infinity. An inexact positive value rounds up in magnitude, and an inexact negative value is truncated.
- R5: If every discarded bit is 0, `out_mant` equals `in_mant` in every mode, and `out_inexact` and `out_carry` are 0.
- R6: Precision codes are 00 extended (64 kept bits), 01 single (24), 10 double (53), and 11 is treated as extended. When `in_force_en` is 1, `in_force_prec` sets the precision. Otherwise `in_prec` sets it for an FP-register destination (`in_dst_reg`=1) and `in_dst_fmt` sets it for any other destination. Kept bits are left-aligned in `out_mant` and the bits below them are 0.
- R7: If rounding up overflows the kept field, `out_carry` is 1 and `out_mant` is 1 followed by 63 zeros.
- R8: `out_post_trap` is 1 exactly when the operation is inexact, `trap_en` is 1 and `in_dst_reg` is 0. With `trap_en` at 0, no trap is reported, and the rounded result is still delivered.
- R9: An accepted inexact operation with `trap_en`=1 and `in_dst_reg`=1 sets `pend_exc`. The next operation accepted while `pend_exc` is set carries `out_pre_trap`=1. `pend_exc` clears only on `exc_ack`, and a new setting takes priority over the clear.
- R10: `inex_sticky` is set by any accepted inexact operation. It stays set until `flag_clr`, and a new setting takes priority over the clear.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output payload is stable. Results leave in the order the operations were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_sign | input | 1 | Sign of the value |
| in_mant | input | 64 | Mantissa, MSB first |
| in_ext | input | 8 | Extra low-order bits below the mantissa |
| in_mode | input | 2 | Rounding mode code |
| in_prec | input | 2 | Precision field used for FP-register destinations |
| in_dst_reg | input | 1 | 1: FP register destination, 0: store-out (memory or integer register) |
| in_dst_fmt | input | 2 | Precision code of the store-out destination format |
| in_force_en | input | 1 | Instruction forces its own precision |
| in_force_prec | input | 2 | Forced precision code |
| trap_en | input | 1 | Inexact trap enable |
| flag_clr | input | 1 | Clears the sticky inexact flag |
| exc_ack | input | 1 | Acknowledges the pending exception |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Sign of the result |
| out_mant | output | 64 | Rounded mantissa, left-aligned |
| out_carry | output | 1 | Mantissa overflowed while rounding |
| out_inexact | output | 1 | This result is inexact |
| out_post_trap | output | 1 | Trap taken after this store-out instruction |
| out_pre_trap | output | 1 | Pre-instruction trap taken on this instruction |
| inex_sticky | output | 1 | Sticky inexact status |
| pend_exc | output | 1 | An inexact exception is pending |

## Verification
A wrong guard or sticky position shows up one cycle after acceptance as an off-by-one kept LSB, or as a wrong `out_inexact` on the same result. A wrong precision choice moves the zeroed tail of `out_mant` on that same result. A pending flag that clears early or sets at the wrong time first shows on `out_pre_trap` of the next accepted operation. A lost sticky flag shows on `inex_sticky` from the edge after the inexact operation. A broken back-pressure path shows as a reordered, duplicated or lost result in the output stream.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;
  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_ZERO = 2'b01;
  localparam logic [1:0] RM_NEG  = 2'b10;
  localparam logic [1:0] RM_POS  = 2'b11;

  localparam logic [1:0] PR_EXT = 2'b00;
  localparam logic [1:0] PR_SGL = 2'b01;
  localparam logic [1:0] PR_DBL = 2'b10;

  localparam int SGL_BITS = 24;
  localparam int DBL_BITS = 53;
endpackage

// File: rtl/fpr_prec_sel.sv
`timescale 1ns/1ps
module fpr_prec_sel (
  input  logic       dst_reg,
  input  logic [1:0] prec_field,
  input  logic [1:0] dst_fmt,
  input  logic       force_en,
  input  logic [1:0] force_prec,
  output logic [1:0] prec_sel
);
  // A forced precision wins. Otherwise the destination kind picks the source.
  always_comb begin
    if (force_en)     prec_sel = force_prec;
    else if (dst_reg) prec_sel = prec_field;
    else              prec_sel = dst_fmt;
  end
endmodule

// File: rtl/fpr_rounder.sv
`timescale 1ns/1ps
module fpr_rounder #(
  parameter int MW = 64,
  parameter int XW = 8
) (
  input  logic          sign,
  input  logic [MW-1:0] mant,
  input  logic [XW-1:0] ext,
  input  logic [1:0]    mode,
  input  logic [1:0]    prec,
  output logic [MW-1:0] res_mant,
  output logic          carry,
  output logic          inexact
);
  import fpr_pkg::*;
  localparam int W = MW + XW;
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] full, kept, lowmask, stickmask, sum, shifted;
  logic       guard, sticky, lsb, inc;
  int         kb, sh;

  always_comb begin
    case (prec)
      PR_SGL:  kb = SGL_BITS;
      PR_DBL:  kb = DBL_BITS;
      default: kb = MW;
    endcase
    sh        = W - kb;
    full      = {1'b0, mant, ext};
    lowmask   = (ONE << sh) - ONE;
    stickmask = lowmask >> 1;
    kept      = full >> sh;
    // guard: highest discarded bit; sticky: OR of everything below it
    guard     = |(full & (lowmask & ~stickmask));
    sticky    = |(full & stickmask);
    lsb       = kept[0];
    inexact   = guard | sticky;
    case (mode)
      RM_NEAR: inc = guard & (sticky | lsb);
      RM_ZERO: inc = 1'b0;
      RM_NEG:  inc = inexact & sign;
      default: inc = inexact & ~sign;
    endcase
    sum     = kept + {{W{1'b0}}, inc};
    carry   = |(sum >> kb);
    shifted = sum << (MW - kb);
    res_mant = carry ? {1'b1, {(MW-1){1'b0}}} : shifted[MW-1:0];
  end
endmodule

// File: rtl/fpr_trap_ctl.sv
`timescale 1ns/1ps
module fpr_trap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic inexact,
  input  logic trap_en,
  input  logic dst_reg,
  input  logic flag_clr,
  input  logic exc_ack,
  output logic post_trap,
  output logic pre_trap,
  output logic sticky_q,
  output logic pend_q
);
  logic arm_pend;

  assign arm_pend  = accept & inexact & trap_en & dst_reg;
  assign post_trap = inexact & trap_en & ~dst_reg;
  assign pre_trap  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (accept && inexact) sticky_q <= 1'b1;
      else if (flag_clr)     sticky_q <= 1'b0;
      if (arm_pend)          pend_q   <= 1'b1;
      else if (exc_ack)      pend_q   <= 1'b0;
    end
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !exc_ack |=> pend_q);
  // R9
  pend_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && inexact && trap_en && dst_reg |=> pend_q);
  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q && !flag_clr |=> sticky_q);
  // R10
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && inexact |=> sticky_q);
endmodule

// File: rtl/fp_round_trap.sv
`timescale 1ns/1ps
module fp_round_trap #(
  parameter int MW = 64,
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sign,
  input  logic [MW-1:0] in_mant,
  input  logic [XW-1:0] in_ext,
  input  logic [1:0]    in_mode,
  input  logic [1:0]    in_prec,
  input  logic          in_dst_reg,
  input  logic [1:0]    in_dst_fmt,
  input  logic          in_force_en,
  input  logic [1:0]    in_force_prec,
  input  logic          trap_en,
  input  logic          flag_clr,
  input  logic          exc_ack,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sign,
  output logic [MW-1:0] out_mant,
  output logic          out_carry,
  output logic          out_inexact,
  output logic          out_post_trap,
  output logic          out_pre_trap,
  output logic          inex_sticky,
  output logic          pend_exc
);
  import fpr_pkg::*;

  logic          accept;
  logic [1:0]    prec_sel;
  logic [MW-1:0] rnd_mant;
  logic          rnd_carry, rnd_inexact, post_trap, pre_trap;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  fpr_prec_sel u_prec (
    .dst_reg(in_dst_reg), .prec_field(in_prec), .dst_fmt(in_dst_fmt),
    .force_en(in_force_en), .force_prec(in_force_prec), .prec_sel(prec_sel)
  );

  fpr_rounder #(.MW(MW), .XW(XW)) u_rnd (
    .sign(in_sign), .mant(in_mant), .ext(in_ext), .mode(in_mode), .prec(prec_sel),
    .res_mant(rnd_mant), .carry(rnd_carry), .inexact(rnd_inexact)
  );

  fpr_trap_ctl u_trap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .inexact(rnd_inexact),
    .trap_en(trap_en), .dst_reg(in_dst_reg), .flag_clr(flag_clr), .exc_ack(exc_ack),
    .post_trap(post_trap), .pre_trap(pre_trap), .sticky_q(inex_sticky), .pend_q(pend_exc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sign      <= 1'b0;
      out_mant      <= '0;
      out_carry     <= 1'b0;
      out_inexact   <= 1'b0;
      out_post_trap <= 1'b0;
      out_pre_trap  <= 1'b0;
    end else if (accept) begin
      out_sign      <= in_sign;
      out_mant      <= rnd_mant;
      out_carry     <= rnd_carry;
      out_inexact   <= rnd_inexact;
      out_post_trap <= post_trap;
      out_pre_trap  <= pre_trap;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_inexact)
      && $stable(out_pre_trap));
  // R5
  exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !rnd_inexact |=> out_mant == $past(in_mant) && !out_carry && !out_inexact);
  // R2
  trunc_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_mode == RM_ZERO |=> !out_carry);
  // R8
  post_needs_inex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_post_trap |-> out_inexact);
endmodule

// File: tb/test_fp_round_trap.sv
`timescale 1ns/1ps
module test_fp_round_trap;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_sign = 0;
  logic [63:0] in_mant = '0;
  logic [7:0]  in_ext = '0;
  logic [1:0]  in_mode = 0, in_prec = 0, in_dst_fmt = 0, in_force_prec = 0;
  logic in_dst_reg = 0, in_force_en = 0, trap_en = 0, flag_clr = 0, exc_ack = 0;
  logic out_valid, out_ready = 1, out_sign, out_carry, out_inexact, out_post_trap, out_pre_trap;
  logic [63:0] out_mant;
  logic inex_sticky, pend_exc;

  always #2.5 clk = ~clk;

  fp_round_trap i_fp_round_trap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_mant(in_mant), .in_ext(in_ext), .in_mode(in_mode),
    .in_prec(in_prec), .in_dst_reg(in_dst_reg), .in_dst_fmt(in_dst_fmt),
    .in_force_en(in_force_en), .in_force_prec(in_force_prec), .trap_en(trap_en),
    .flag_clr(flag_clr), .exc_ack(exc_ack), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_mant(out_mant), .out_carry(out_carry),
    .out_inexact(out_inexact), .out_post_trap(out_post_trap), .out_pre_trap(out_pre_trap),
    .inex_sticky(inex_sticky), .pend_exc(pend_exc)
  );

  typedef struct {
    logic        sign;
    logic [63:0] mant;
    logic        carry, inex, post, pre;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0, stall = 0;
  logic pend_m = 0, sticky_m = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Independent reference: quotient/remainder arithmetic instead of bit masks.
  function automatic exp_t model(input logic s, input logic [63:0] m, input logic [7:0] x,
                                 input logic [1:0] mode, input int kb);
    exp_t e;
    logic [72:0] full, p, q, r, half, sum;
    logic inc, inex;
    full = {1'b0, m, x};
    p    = 73'd1 << (72 - kb);
    q    = full / p;
    r    = full % p;
    half = p >> 1;
    inex = (r != 0);
    case (mode)
      2'b00:   inc = (r > half) || (r == half && q[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = inex && s;
      default: inc = inex && !s;
    endcase
    sum = q + {72'd0, inc};
    e.sign = s;
    e.inex = inex;
    if (sum == (73'd1 << kb)) begin
      e.carry = 1'b1;
      e.mant  = 64'h8000_0000_0000_0000;
    end else begin
      e.carry = 1'b0;
      e.mant  = 64'(sum << (64 - kb));
    end
    return e;
  endfunction

  task automatic send(input logic s, input logic [63:0] m, input logic [7:0] x,
                      input logic [1:0] mode, input logic [1:0] prec, input logic dreg,
                      input logic [1:0] dfmt, input logic fen, input logic [1:0] fprec,
                      input logic te, input string tag);
    logic [1:0] eff;
    int kb;
    exp_t e;
    @(negedge clk);
    in_sign = s; in_mant = m; in_ext = x; in_mode = mode; in_prec = prec;
    in_dst_reg = dreg; in_dst_fmt = dfmt; in_force_en = fen; in_force_prec = fprec;
    trap_en = te; in_valid = 1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    eff = fen ? fprec : (dreg ? prec : dfmt);
    kb  = (eff == 2'b01) ? 24 : (eff == 2'b10) ? 53 : 64;
    e = model(s, m, x, mode, kb);
    e.post = e.inex && te && !dreg;
    e.pre  = pend_m;
    e.tag  = tag;
    if (e.inex && te && dreg) pend_m = 1;
    if (e.inex) sticky_m = 1;
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: sets out_ready, then compares the item handed over at the next edge.
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 4 != 3 && cyc % 7 != 0) : 1'b1;
      #1;
      if (rst_n) begin
        // R11 ready rule
        chk(in_ready == (!out_valid || out_ready), "R11", "in_ready", {67'd0, in_ready},
            {67'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            chk(0, "R11", "unexpected result", {4'd0, out_mant}, 68'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(out_mant == e.mant && out_carry == e.carry && out_inexact == e.inex &&
                out_post_trap == e.post && out_pre_trap == e.pre && out_sign == e.sign,
                e.tag, "result {carry,inex,post,pre,mant}",
                {out_carry, out_inexact, out_post_trap, out_pre_trap, out_mant},
                {e.carry, e.inex, e.post, e.pre, e.mant});
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", sb.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // Reset state (R11, R10, R9)
    chk(!out_valid, "R11", "out_valid after reset", {67'd0, out_valid}, 68'd0);
    chk(!inex_sticky, "R10", "sticky after reset", {67'd0, inex_sticky}, 68'd0);
    chk(!pend_exc, "R9", "pending after reset", {67'd0, pend_exc}, 68'd0);

    // R1 nearest-even at single precision (kept LSB is bit 40, guard is bit 39)
    send(0, 64'h8000_0080_0000_0000, 8'h00, 2'b00, 2'b01, 1, 0, 0, 0, 0, "R1 tie-even-down");
    send(0, 64'h8000_0180_0000_0000, 8'h00, 2'b00, 2'b01, 1, 0, 0, 0, 0, "R1 tie-even-up");
    send(0, 64'h8000_0080_0000_0001, 8'h00, 2'b00, 2'b01, 1, 0, 0, 0, 0, "R1 above-half");
    send(1, 64'h8000_0070_0000_0000, 8'hFF, 2'b00, 2'b01, 1, 0, 0, 0, 0, "R1 below-half");
    send(0, 64'h8000_0000_0000_0001, 8'h80, 2'b00, 2'b00, 1, 0, 0, 0, 0, "R1 ext tie");
    // R2 truncation
    send(0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 2'b01, 2'b10, 1, 0, 0, 0, 0, "R2 trunc pos");
    send(1, 64'hC000_00FF_FFFF_FFFF, 8'h01, 2'b01, 2'b01, 1, 0, 0, 0, 0, "R2 trunc neg");
    // R3 toward minus infinity
    send(1, 64'h8000_0000_0000_0001, 8'h00, 2'b10, 2'b01, 1, 0, 0, 0, 0, "R3 neg up");
    send(0, 64'h8000_0000_0000_0001, 8'h00, 2'b10, 2'b01, 1, 0, 0, 0, 0, "R3 pos trunc");
    // R4 toward plus infinity
    send(0, 64'h8000_0000_0000_0000, 8'h01, 2'b11, 2'b00, 1, 0, 0, 0, 0, "R4 pos up");
    send(1, 64'h8000_0000_0000_0000, 8'h01, 2'b11, 2'b00, 1, 0, 0, 0, 0, "R4 neg trunc");
    drain();
    // R10 clear the sticky flag, then exact operations must leave it clear
    @(negedge clk); flag_clr = 1; @(posedge clk); #1 flag_clr = 0; sticky_m = 0;
    @(negedge clk);
    chk(inex_sticky == 0, "R10", "sticky after clear", {67'd0, inex_sticky}, 68'd0);
    // R5 exact values in every mode
    for (int md = 0; md < 4; md++)
      send(md[0], 64'hABCD_E100_0000_0000, 8'h00, md[1:0], 2'b01, 1, 0, 0, 0, 1, "R5 exact");
    send(1, 64'h9234_5678_9ABC_DEF1, 8'h00, 2'b10, 2'b00, 0, 0, 0, 0, 1, "R5 exact ext");
    drain();
    chk(inex_sticky == 0, "R5", "sticky after exact ops", {67'd0, inex_sticky}, 68'd0);
    chk(pend_exc == 0, "R5", "pending after exact ops", {67'd0, pend_exc}, 68'd0);
    // R7 carry-out
    send(0, 64'hFFFF_FF80_0000_0000, 8'h00, 2'b00, 2'b01, 1, 0, 0, 0, 0, "R7 carry nearest");
    send(1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 2'b10, 2'b00, 1, 0, 0, 0, 0, "R7 carry ext");
    // R6 precision choice
    send(0, 64'h8000_0000_0000_0FFF, 8'h00, 2'b01, 2'b11, 1, 2'b01, 0, 0, 0, "R6 field ext");
    send(0, 64'h8000_0000_0000_0FFF, 8'h00, 2'b01, 2'b01, 0, 2'b10, 0, 0, 0, "R6 dst dbl");
    send(0, 64'h8000_0000_0000_0FFF, 8'h00, 2'b01, 2'b10, 1, 2'b00, 1, 2'b01, 0, "R6 force sgl");
    send(0, 64'h8000_0000_0000_0FFF, 8'h00, 2'b01, 2'b01, 0, 2'b01, 1, 2'b00, 0, "R6 force ext");
    drain();
    chk(inex_sticky == 1, "R10", "sticky after inexact", {67'd0, inex_sticky}, 68'd1);
    // R8 store-out traps
    send(0, 64'h8000_0000_0000_0001, 8'h00, 2'b00, 2'b00, 0, 2'b01, 0, 0, 0, "R8 trap off");
    send(0, 64'h8000_0000_0000_0001, 8'h00, 2'b00, 2'b00, 0, 2'b01, 0, 0, 1, "R8 post trap");
    drain();
    chk(pend_exc == 0, "R8", "store-out leaves no pending", {67'd0, pend_exc}, 68'd0);
    // R9 pending exception for register destination
    send(0, 64'h8000_0000_0000_0001, 8'h00, 2'b00, 2'b01, 1, 0, 0, 0, 1, "R9 arm");
    drain();
    chk(pend_exc == 1, "R9", "pending set", {67'd0, pend_exc}, 68'd1);
    send(0, 64'h8000_0000_0000_0000, 8'h00, 2'b00, 2'b00, 1, 0, 0, 0, 0, "R9 pre trap");
    drain();
    chk(pend_exc == 1, "R9", "pending held without ack", {67'd0, pend_exc}, 68'd1);
    @(negedge clk); exc_ack = 1; @(posedge clk); #1 exc_ack = 0; pend_m = 0;
    @(negedge clk);
    chk(pend_exc == 0, "R9", "pending after ack", {67'd0, pend_exc}, 68'd0);
    send(0, 64'h8000_0000_0000_0000, 8'h00, 2'b00, 2'b00, 1, 0, 0, 0, 0, "R9 no pre after ack");
    drain();
    // R11 random stream under back-pressure
    stall = 1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] m;
      m = {$urandom, $urandom};
      m[63] = 1'b1;
      if (i % 5 == 0) m[39:0] = '0;
      send(1'($urandom), m, 8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
           2'($urandom), (i % 6 == 0), 2'($urandom), 1'($urandom), "R11 stream");
    end
    drain();
    stall = 0;
    chk(pend_exc == pend_m, "R9", "pending after stream", {67'd0, pend_exc}, {67'd0, pend_m});
    chk(inex_sticky == sticky_m, "R10", "sticky after stream", {67'd0, inex_sticky},
        {67'd0, sticky_m});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule